// File: doc/BRIEF.md
# Two-Wire Slave Register File with Atomic Time Snapshot

This block is a two-wire (I2C) slave that runs on the system clock. It samples the bus clock and data lines and pulls the data line low through an open-drain enable. Behind the slave sits a 64-byte address space. Locations 00h to 06h belong to a time counter that lives outside the block. Location 07h holds a control byte, and locations 08h to 3Fh are general-purpose RAM.

A register pointer selects the location being read or written. It advances after every data byte and runs past 3Fh to 00h. Reads of the time locations never see the live counter directly. They see a shadow copy, which is reloaded as a whole on each START, on each STOP and whenever the pointer rolls over to 00h. A burst read therefore returns one coherent time value, even while the counter keeps ticking.

Bytes written to the time locations are not stored in the block. They leave through a valid/ready write port towards the counter. Payload and `tw_valid` stay stable until `tw_ready` is seen high at a clock edge. If the counter has not accepted one write when the next time write arrives, the newer write replaces it. The consumer must therefore accept within one byte time on the bus (nine bus clocks). The live time enters as a plain vector and the control byte leaves as a plain vector.

Top module: `i2c_time_regfile`

## Requirements
- R1: An address byte of D0h or D1h (7-bit address 1101000, bit 0 the direction: 0 write, 1 read) is acknowledged by holding SDA low during the ninth bus clock.
- R2: Any other address byte is not acknowledged. Until the next START the slave then drives nothing and changes neither the pointer nor any storage.
- R3: In a write transfer, the first byte after the address loads its low six bits into the pointer. Each later byte is stored at the pointer, and then the pointer advances by one. Every byte is acknowledged.
- R4: The pointer advances from 3Fh to 00h, in reads and in writes, and a burst continues at 00h.
- R5: A read starts at the current pointer, which is the last value left there if no pointer byte came first. Each byte is sent MSB first, and the pointer advances after each byte sent. The read continues while the master acknowledges. After a NACK, and after a STOP, SDA is released.
- R6: A repeated START that follows a pointer write leaves the pointer unchanged, so a read then begins at that location.
- R7: Reads of 00h–06h return the snapshot of `time_live_i`, where byte k is bits 8k+7..8k. The snapshot is loaded at every START, at every STOP and at every pointer rollover to 00h. Changes of the live value between loads stay invisible.
- R8: A byte written to location k in 00h–06h appears on the write port with `tw_addr`=k and `tw_data` equal to the byte. It is not stored locally. `tw_valid` and the payload hold until `tw_ready`.
- R9: A byte written to 07h appears on `ctrl_o` from the acknowledge of that byte onward. Bytes written to 08h–3Fh are read back unchanged.
- R10: `sda_oe` changes only while the synchronized SCL is low, except at a START or STOP.
- R11: After reset, `sda_oe`=0, `tw_valid`=0, `ctrl_o`=CTRL_RST (default 00h) and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| time_live_i | input | TIME_REGS*8 | Live time bytes, byte k at bits 8k+7..8k |
| tw_valid | output | 1 | Time write pending |
| tw_ready | input | 1 | Counter accepts the pending time write |
| tw_addr | output | $clog2(TIME_REGS) | Time location index of the write |
| tw_data | output | 8 | Time byte to write |
| ctrl_o | output | 8 | Control byte at location 07h |

## Verification
The pointer rollover and the snapshot reload fall in the same clock cycle. In a write burst, that cycle also holds the store to 3Fh or the time write at the wrap. A full 66-byte read burst provokes this: it starts at 00h, and the live time is changed after the third byte. The bench expects bytes 00h–06h to carry the value at START. It expects the bytes read after the wrap to carry the value changed mid-burst. A write burst crossing 3Fh must emit a port write for index 0 in the very byte that follows the store to 3Fh.

// File: rtl/i2c_trf_pkg.sv
package i2c_trf_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // data edge while clock stays high marks a bus condition
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_trf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic              wr_first,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_stb
);

  bus_st_e           st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw, acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      rw       <= 1'b0;
      acked    <= 1'b0;
      wr_first <= 1'b0;
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[BYTE_W-2:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  rw       <= sh[0];
                  wr_first <= 1'b1;
                  st       <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                wr_stb <= 1'b1;
                st     <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              cnt      <= '0;
              wr_first <= 1'b0;
              st       <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                rd_stb <= 1'b1;
                st     <= ST_RD_ACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              acked <= ~sda_q;
            end else if (scl_fall) begin
              if (acked) begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_byte = sh;

endmodule

// File: rtl/i2c_time_regs.sv
module i2c_time_regs
  import i2c_trf_pkg::*;
#(
  parameter int          TIME_REGS = 7,
  parameter int          SPACE     = 64,
  parameter logic [7:0]  CTRL_RST  = 8'h00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic                          wr_first,
  input  logic [BYTE_W-1:0]             wr_byte,
  input  logic                          rd_stb,
  input  logic                          snap_evt,
  input  logic [TIME_REGS*BYTE_W-1:0]   time_live_i,
  input  logic                          tw_ready,
  output logic [BYTE_W-1:0]             rd_byte,
  output logic                          tw_valid,
  output logic [$clog2(TIME_REGS)-1:0]  tw_addr,
  output logic [BYTE_W-1:0]             tw_data,
  output logic [BYTE_W-1:0]             ctrl_o,
  output logic [$clog2(SPACE)-1:0]      ptr_o,
  output logic [TIME_REGS*BYTE_W-1:0]   snap_o
);

  localparam int             PW       = $clog2(SPACE);
  localparam int             TW       = $clog2(TIME_REGS);
  localparam logic [PW-1:0]  TIME_END = PW'(TIME_REGS);
  localparam logic [PW-1:0]  LAST     = PW'(SPACE - 1);

  logic [BYTE_W-1:0]           mem [SPACE];
  logic [TIME_REGS*BYTE_W-1:0] snap;
  logic [PW-1:0]               ptr;
  logic                        bump, wrap, store;

  assign store = wr_stb & ~wr_first;
  assign bump  = rd_stb | store;
  assign wrap  = bump && (ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      snap <= '0;
    end else begin
      if (wr_stb && wr_first) ptr <= wr_byte[PW-1:0];
      else if (bump)          ptr <= wrap ? '0 : ptr + PW'(1);
      if (snap_evt || wrap)   snap <= time_live_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE; i++)
        mem[i] <= (i == TIME_REGS) ? CTRL_RST : '0;
    end else if (store && ptr >= TIME_END) begin
      mem[ptr] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_valid <= 1'b0;
      tw_addr  <= '0;
      tw_data  <= '0;
    end else if (store && ptr < TIME_END) begin
      tw_valid <= 1'b1;
      tw_addr  <= ptr[TW-1:0];
      tw_data  <= wr_byte;
    end else if (tw_ready) begin
      tw_valid <= 1'b0;
    end
  end

  always_comb begin
    if (ptr < TIME_END) rd_byte = snap[{ptr[TW-1:0], 3'b000} +: BYTE_W];
    else                rd_byte = mem[ptr];
  end

  assign ctrl_o = mem[TIME_REGS];
  assign ptr_o  = ptr;
  assign snap_o = snap;

endmodule

// File: rtl/i2c_time_regfile.sv
module i2c_time_regfile
  import i2c_trf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         TIME_REGS   = 7,
  parameter int         SPACE       = 64,
  parameter logic [7:0] CTRL_RST    = 8'h00
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_oe,
  input  logic [TIME_REGS*8-1:0]        time_live_i,
  output logic                          tw_valid,
  input  logic                          tw_ready,
  output logic [$clog2(TIME_REGS)-1:0]  tw_addr,
  output logic [7:0]                    tw_data,
  output logic [7:0]                    ctrl_o
);

  localparam int PTR_W = $clog2(SPACE);

  logic              scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_stb, wr_first, rd_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [PTR_W-1:0]  ptr;
  logic [TIME_REGS*BYTE_W-1:0] snap_v;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_bit_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_first(wr_first), .wr_byte(wr_byte), .rd_stb(rd_stb)
  );

  i2c_time_regs #(.TIME_REGS(TIME_REGS), .SPACE(SPACE), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_first(wr_first),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .snap_evt(start_evt | stop_evt),
    .time_live_i(time_live_i), .tw_ready(tw_ready), .rd_byte(rd_byte),
    .tw_valid(tw_valid), .tw_addr(tw_addr), .tw_data(tw_data),
    .ctrl_o(ctrl_o), .ptr_o(ptr), .snap_o(snap_v)
  );

endmodule

// File: rtl/i2c_time_regfile_chk.sv
module i2c_time_regfile_chk #(
  parameter int TIME_REGS = 7,
  parameter int PW        = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         scl_q,
  input logic                         sda_oe,
  input logic                         start_evt,
  input logic                         stop_evt,
  input logic [PW-1:0]                ptr,
  input logic [TIME_REGS*8-1:0]       snap_v,
  input logic [TIME_REGS*8-1:0]       time_live_i,
  input logic                         tw_valid,
  input logic                         tw_ready,
  input logic [$clog2(TIME_REGS)-1:0] tw_addr,
  input logic [7:0]                   tw_data
);

  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_q);

  assert_tw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_addr) && $stable(tw_data)));

  assert_tw_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> (32'(tw_addr) < TIME_REGS));

  assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_rstart_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> $stable(ptr));

  assert_cond_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> (snap_v == $past(time_live_i)));

endmodule

bind i2c_time_regfile i2c_time_regfile_chk #(.TIME_REGS(TIME_REGS), .PW(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .ptr(ptr), .snap_v(snap_v),
  .time_live_i(time_live_i), .tw_valid(tw_valid), .tw_ready(tw_ready),
  .tw_addr(tw_addr), .tw_data(tw_data)
);

// File: tb/i2c_time_regfile_tb.sv
module i2c_time_regfile_tb;

  localparam time Q = 50ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_oe, sda_line;
  logic [55:0] time_live;
  logic        tw_valid, tw_ready;
  logic [2:0]  tw_addr;
  logic [7:0]  tw_data, ctrl_o;

  int compared = 0, mismatched = 0, rdy_cnt = 0, cap_n = 0;
  bit done = 0;
  logic [2:0] cap_addr [16];
  logic [7:0] cap_data [16];

  always #5ns clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_time_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .time_live_i(time_live), .tw_valid(tw_valid), .tw_ready(tw_ready),
    .tw_addr(tw_addr), .tw_data(tw_data), .ctrl_o(ctrl_o)
  );

  // consumer of the time write port, stalls two cycles out of three
  always @(negedge clk) begin
    rdy_cnt++;
    tw_ready = (rdy_cnt % 3 == 0);
    if (rst_n && tw_valid && tw_ready && cap_n < 16) begin
      cap_addr[cap_n] = tw_addr;
      cap_data[cap_n] = tw_data;
      cap_n++;
    end
  end

  function automatic logic [7:0] ram_pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [55:0] live_set(logic [7:0] base);
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = base + 8'(k);
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic bit_v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(bit_v);
    ack = ~bit_v;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic bit_v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(bit_v);
      b[i] = bit_v;
    end
    put_bit(~give_ack);
  endtask

  // pointer write then repeated START into a read
  task automatic point_read(input logic [7:0] p);
    logic ack;
    bus_start;
    send_byte(8'hD0, ack); chk("R1 write address ack", {7'b0, ack}, 8'h01);
    send_byte(p, ack);     chk("R3 pointer byte ack", {7'b0, ack}, 8'h01);
    bus_start;
    send_byte(8'hD1, ack); chk("R6 read address after Sr ack", {7'b0, ack}, 8'h01);
  endtask

  initial begin
    logic       ack;
    logic [7:0] b;
    int         base;
    time_live = live_set(8'h10);
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 sda_oe at reset", {7'b0, sda_oe}, 8'h00);
    chk("R11 tw_valid at reset", {7'b0, tw_valid}, 8'h00);
    chk("R11 ctrl_o at reset", ctrl_o, 8'h00);
    rst_n = 1'b1;
    #(4*Q);
    // R11 pointer at 00h after reset: current read returns snapshot byte 0
    bus_start;
    send_byte(8'hD1, ack); chk("R1 read address ack", {7'b0, ack}, 8'h01);
    recv_byte(1'b0, b);    chk("R11 read from reset pointer", b, 8'h10);
    bus_stop;

    // R3 write burst 07h..3Fh, then wrap into the time locations (R4, R8)
    base = cap_n;
    bus_start;
    send_byte(8'hD0, ack); chk("R1 write address ack", {7'b0, ack}, 8'h01);
    send_byte(8'h07, ack); chk("R3 pointer ack", {7'b0, ack}, 8'h01);
    for (int a = 7; a < 64; a++) begin
      send_byte(ram_pat(a), ack);
      chk("R3 data byte ack", {7'b0, ack}, 8'h01);
      if (a == 7) chk("R9 ctrl_o after ack", ctrl_o, ram_pat(7));
    end
    for (int k = 0; k < 7; k++) begin
      send_byte(8'h40 + 8'(k), ack);
      chk("R4 byte after wrap ack", {7'b0, ack}, 8'h01);
    end
    bus_stop;
    #(4*Q);
    chk("R8 port write count", 8'(cap_n - base), 8'd7);
    for (int k = 0; k < 7; k++) begin
      chk("R4 R8 port index after wrap", {5'b0, cap_addr[base+k]}, 8'(k));
      chk("R8 port data", cap_data[base+k], 8'h40 + 8'(k));
    end

    // full read burst from 00h across the wrap (R5, R7, R4)
    point_read(8'h00);
    for (int i = 0; i < 66; i++) begin
      recv_byte(i < 65, b);
      if (i < 7)       chk("R7 R8 snapshot byte, not written value", b, 8'h10 + 8'(i));
      else if (i < 64) chk("R5 R9 burst read of stored byte", b, ram_pat(i));
      else             chk("R4 byte after wrap from reloaded snapshot", b, 8'h20 + 8'(i - 64));
      if (i == 2) time_live = live_set(8'h20);
    end
    chk("R5 sda released after NACK", {7'b0, sda_line}, 8'h01);
    bus_stop;

    // current-pointer read: pointer left at 02h (R5), snapshot from START (R7)
    time_live = live_set(8'h30);
    bus_start;
    send_byte(8'hD1, ack); chk("R1 read address ack", {7'b0, ack}, 8'h01);
    recv_byte(1'b0, b);    chk("R5 read at current pointer", b, 8'h32);
    bus_stop;

    // foreign addresses are ignored (R2)
    bus_start;
    send_byte(8'hA0, ack); chk("R2 foreign address no ack", {7'b0, ack}, 8'h00);
    send_byte(8'h08, ack); chk("R2 ignored byte no ack", {7'b0, ack}, 8'h00);
    send_byte(8'h55, ack); chk("R2 ignored byte no ack", {7'b0, ack}, 8'h00);
    bus_stop;
    bus_start;
    send_byte(8'hD3, ack); chk("R2 near address no ack", {7'b0, ack}, 8'h00);
    bus_stop;
    bus_start;
    send_byte(8'hD1, ack); chk("R1 read address ack", {7'b0, ack}, 8'h01);
    recv_byte(1'b0, b);    chk("R2 pointer unchanged by foreign traffic", b, 8'h33);
    bus_stop;
    point_read(8'h08);
    recv_byte(1'b0, b);    chk("R2 storage unchanged by foreign traffic", b, ram_pat(8));
    bus_stop;

    // control location written directly (R9)
    bus_start;
    send_byte(8'hD0, ack); send_byte(8'h07, ack);
    send_byte(8'h5A, ack); chk("R9 ctrl_o updated at ack", ctrl_o, 8'h5A);
    bus_stop;

    // sweep every time index through single writes (R8)
    base = cap_n;
    for (int k = 0; k < 7; k++) begin
      bus_start;
      send_byte(8'hD0, ack); send_byte(8'(k), ack);
      send_byte(8'h80 + 8'(3*k), ack); chk("R8 time write ack", {7'b0, ack}, 8'h01);
      bus_stop;
    end
    #(4*Q);
    for (int k = 0; k < 7; k++) begin
      chk("R8 sweep port index", {5'b0, cap_addr[base+k]}, 8'(k));
      chk("R8 sweep port data", cap_data[base+k], 8'h80 + 8'(3*k));
    end

    // short burst across 3Fh with stores on both sides (R4)
    base = cap_n;
    bus_start;
    send_byte(8'hD0, ack); send_byte(8'h3E, ack);
    send_byte(8'hE1, ack); send_byte(8'hE2, ack); send_byte(8'h99, ack);
    bus_stop;
    #(4*Q);
    chk("R4 wrap write goes to index 0", {5'b0, cap_addr[base]}, 8'h00);
    chk("R4 wrap write data", cap_data[base], 8'h99);
    point_read(8'h3E);
    recv_byte(1'b1, b); chk("R4 stored at 3Eh", b, 8'hE1);
    recv_byte(1'b0, b); chk("R4 stored at 3Fh", b, 8'hE2);
    bus_stop;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule